// File: doc/BRIEF.md
# Output Compare Unit with Shared Pin Output

This block watches a free-running 16-bit counter and flags the moment it reaches a value chosen by software. The CPU loads the 16-bit compare value over a byte-wide register bus, high byte first and low byte second. A high-byte write suspends all compares until the matching low byte arrives, so a half-updated value can never produce a false match.

The comparison is not made on every clock. An internal divide-by-4 phase counter produces a compare strobe once every four internal clocks, and a match counts only on a strobe cycle. A match sets a sticky compare flag. The flag drives an interrupt request when the interrupt enable is 1. It can also be routed onto bit 0 of a shared port in place of the port's own data and direction.

To clear the flag, software first reads the status register while the flag is set, and then reads or writes the compare low byte. The free-running counter, the prescaler and the rest of the port logic sit outside this block.

Top module: `ocmp_unit`

## Requirements
- R1: The compare strobe `cmp_strobe` is high for one clock in every 4 clocks. The first strobe comes on the 4th clock after reset. A counter value equal to the compare value on a cycle without a strobe has no effect on the flag.
- R2: When `cnt_val` equals the stored compare value on a strobe cycle, and compares are not suspended, `cmp_flag` is 1 from the next clock onward. A counter value that differs from the compare value does not set the flag.
- R3: `irq` is 1 exactly when `cmp_flag` is 1 and `cmp_ie` is 1. The relation is combinational.
- R4: A write to the compare high byte (address 0) suspends compares. Matches on later strobes are ignored until the compare low byte (address 1) is written.
- R5: A read of the status register (address 2) while the flag is 1 arms the clear. The next read or write of address 1 then clears the flag. A read or write of address 1 with no armed clear leaves the flag set. A status read made while the flag is 0 does not arm the clear.
- R6: A further match on a later strobe while the flag is already set leaves the flag at 1.
- R7: When `pin_sel` is 1, `pin_out` equals `cmp_flag` and `pin_oe` is 1. When `pin_sel` is 0, `pin_out` equals `port_dout0` and `pin_oe` equals `port_dir0`.
- R8: After reset, the compare value is 0xFFFF, `cmp_flag` and `irq` are 0, and compares are not suspended.
- R9: Reads return data combinationally on `bus_rdata`. Address 0 returns the compare high byte and address 1 the low byte. Address 2 returns the status byte, which carries the flag at bit 6 with all other bits 0. Address 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Free-running counter value |
| bus_addr | input | 2 | Register select: 0 high byte, 1 low byte, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_rdata | output | 8 | Read data |
| cmp_ie | input | 1 | Compare interrupt enable |
| pin_sel | input | 1 | 1 routes the flag onto port pin 0 |
| port_dout0 | input | 1 | Port data bit 0 from the port logic |
| port_dir0 | input | 1 | Port direction bit 0 from the port logic |
| cmp_strobe | output | 1 | Compare strobe, one clock in four |
| cmp_flag | output | 1 | Output compare flag |
| irq | output | 1 | Timer interrupt request |
| pin_out | output | 1 | Value driven on port pin 0 |
| pin_oe | output | 1 | Output enable of port pin 0 |

## Verification
The comparison is exercised with several counter patterns. A matching value held only over the three non-strobe clocks shows that the strobe gates the check. A matching value on a strobe cycle confirms the flag sets. A non-matching value on a strobe confirms the flag stays clear. A second compare value separates a true equality test from a stale one.

Matches are also presented after a lone high-byte write and again after the low-byte write, which separates suspended compares from live ones. The clear sequence is tried three ways: without a status read, with a status read taken while the flag was clear, and with a proper status read followed by either a read or a write of the low byte. Together these show that only the armed access clears the flag.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam int STAT_FLAG_BIT = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMP_HI = 2'd0,
    REG_CMP_LO = 2'd1,
    REG_STAT   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  // Equality test between the running count and the programmed value.
  function automatic logic words_match(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] cmp);
    return (cnt ^ cmp) == '0;
  endfunction

  // Next phase of a modulo-N phase counter.
  function automatic int unsigned next_phase(input int unsigned ph,
                                             input int unsigned modulus);
    return (ph + 1 >= modulus) ? 0 : ph + 1;
  endfunction

  // Status byte image for a given flag state.
  function automatic logic [BYTE_W-1:0] status_image(input logic flag);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[STAT_FLAG_BIT] = flag;
    return v;
  endfunction
endpackage

// File: rtl/ocmp_strobe_gen.sv
module ocmp_strobe_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_d = PH_W'(ocmp_pkg::next_phase(int'(ph_q), DIV));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign strobe = (ph_q == PH_LAST);

  generate
    if (DIV > 1) begin : g_strobe_chk
      // R1
      strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe)
        else $error("strobe high on two consecutive clocks");
    end
  endgenerate
endmodule

// File: rtl/ocmp_cmp_regs.sv
module ocmp_cmp_regs
  import ocmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              inhibit,
  output logic              hi_wr,
  output logic              lo_access,
  output logic              stat_rd
);
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              inh_q;
  logic              lo_wr;

  assign hi_wr     = wr_en && (addr == REG_CMP_HI);
  assign lo_wr     = wr_en && (addr == REG_CMP_LO);
  assign lo_access = (wr_en || rd_en) && (addr == REG_CMP_LO);
  assign stat_rd   = rd_en && (addr == REG_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '1;
      lo_q  <= '1;
      inh_q <= 1'b0;
    end else begin
      if (hi_wr) begin
        hi_q  <= wdata;
        inh_q <= 1'b1;
      end
      if (lo_wr) begin
        lo_q  <= wdata;
        inh_q <= 1'b0;
      end
    end
  end

  assign cmp_val = {hi_q, lo_q};
  assign inhibit = inh_q;

  // R4
  hi_suspends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> inhibit)
    else $error("high-byte write did not suspend compares");

  // R4
  lo_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_CMP_LO) |=> !inhibit)
    else $error("low-byte write did not resume compares");
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic stat_rd,
  input  logic lo_access,
  output logic flag
);
  logic flag_q, arm_q, clr;

  assign clr = arm_q && lo_access;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (clr)                   arm_q <= 1'b0;
      else if (stat_rd && flag_q) arm_q <= 1'b1;
    end
  end

  assign flag = flag_q;

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag)
    else $error("match did not set flag");

  // R2
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit))
    else $error("flag rose without a match");

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !lo_access) |=> flag)
    else $error("flag dropped without a low-byte access");

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag)
    else $error("armed low-byte access did not clear flag");
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cmp_ie,
  input  logic              pin_sel,
  input  logic              port_dout0,
  input  logic              port_dir0,
  output logic              cmp_strobe,
  output logic              cmp_flag,
  output logic              irq,
  output logic              pin_out,
  output logic              pin_oe
);
  logic [CNT_W-1:0] cmp_val;
  logic inhibit, hi_wr, lo_access, stat_rd;
  logic hit;

  ocmp_strobe_gen #(.DIV(DIV)) u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(cmp_strobe)
  );

  ocmp_cmp_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .cmp_val  (cmp_val),
    .inhibit  (inhibit),
    .hi_wr    (hi_wr),
    .lo_access(lo_access),
    .stat_rd  (stat_rd)
  );

  assign hit = cmp_strobe && !inhibit && words_match(cnt_val, cmp_val);

  ocmp_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .stat_rd  (stat_rd),
    .lo_access(lo_access),
    .flag     (cmp_flag)
  );

  always_comb begin
    unique case (bus_addr)
      REG_CMP_HI: bus_rdata = cmp_val[CNT_W-1 -: BYTE_W];
      REG_CMP_LO: bus_rdata = cmp_val[BYTE_W-1:0];
      REG_STAT:   bus_rdata = status_image(cmp_flag);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq     = cmp_flag && cmp_ie;
  assign pin_out = pin_sel ? cmp_flag : port_dout0;
  assign pin_oe  = pin_sel ? 1'b1     : port_dir0;

  // R1
  hit_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cmp_strobe)
    else $error("match accepted off strobe");

  // R4
  no_hit_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !hit)
    else $error("match accepted while suspended");

  // R3
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cmp_ie && cmp_flag))
    else $error("interrupt without enabled flag");
endmodule

// File: tb/ocmp_unit_bench.sv
module ocmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_val = '0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        cmp_ie = 1'b0, pin_sel = 1'b0, port_dout0 = 1'b0, port_dir0 = 1'b0;
  logic        cmp_strobe, cmp_flag, irq, pin_out, pin_oe;

  always #10 clk = ~clk;

  ocmp_unit u_ocmp_unit (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .cmp_ie(cmp_ie), .pin_sel(pin_sel),
    .port_dout0(port_dout0), .port_dir0(port_dir0), .cmp_strobe(cmp_strobe),
    .cmp_flag(cmp_flag), .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef enum int {S_FLAG, S_IRQ, S_PIN, S_OE, S_RDATA, S_PERIOD} sig_e;
  typedef struct {
    string       req;
    sig_e        sel;
    logic [15:0] exp;
  } item_t;

  item_t       sb_q[$];
  int          n_cmp = 0, n_bad = 0;
  logic [7:0]  rd_last = '0;
  int          period = 0;
  bit          done = 1'b0;

  function automatic logic [15:0] sample(input sig_e s);
    case (s)
      S_FLAG:  return {15'd0, cmp_flag};
      S_IRQ:   return {15'd0, irq};
      S_PIN:   return {15'd0, pin_out};
      S_OE:    return {15'd0, pin_oe};
      S_RDATA: return {8'd0, rd_last};
      default: return 16'(period);
    endcase
  endfunction

  // Monitor: pops expected items and compares with the live outputs.
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = sample(it.sel);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: %s actual=%h expected=%h", it.req, it.sel.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input string req, input sig_e sel, input logic [15:0] exp);
    item_t it;
    #1;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_strobe();
    step();
    while (!cmp_strobe) step();
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    bus_addr = a; bus_rd = 1'b1;
    #1 rd_last = bus_rdata;
    step();
    bus_rd = 1'b0;
  endtask

  // Present a value on a strobe clock only; counter rests at 0 otherwise.
  task automatic strobe_value(input logic [15:0] v);
    wait_strobe();
    cnt_val = v;
    step();
    cnt_val = 16'h0000;
  endtask

  task automatic clear_flag();
    bus_read(2'd2);
    bus_read(2'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R8 reset state
    expect_val("R8", S_FLAG, 16'd0);
    expect_val("R8", S_IRQ, 16'd0);
    bus_read(2'd0); expect_val("R8", S_RDATA, 16'h00FF);
    bus_read(2'd1); expect_val("R8", S_RDATA, 16'h00FF);

    // R1 strobe period
    wait_strobe();
    period = 0;
    do begin step(); period++; end while (!cmp_strobe);
    expect_val("R1", S_PERIOD, 16'd4);

    // R9 readback of programmed value
    bus_write(2'd0, 8'h12);
    bus_write(2'd1, 8'h34);
    bus_read(2'd0); expect_val("R9", S_RDATA, 16'h0012);
    bus_read(2'd1); expect_val("R9", S_RDATA, 16'h0034);
    bus_read(2'd3); expect_val("R9", S_RDATA, 16'h0000);

    // R1 match present only on non-strobe clocks
    wait_strobe();
    step();
    cnt_val = 16'h1234;
    repeat (3) step();
    cnt_val = 16'h0000;
    step();
    expect_val("R1", S_FLAG, 16'd0);

    // R2 mismatch on strobe
    strobe_value(16'h1235);
    expect_val("R2", S_FLAG, 16'd0);

    // R2 / R3 match on strobe
    cmp_ie = 1'b1;
    strobe_value(16'h1234);
    expect_val("R2", S_FLAG, 16'd1);
    expect_val("R3", S_IRQ, 16'd1);
    cmp_ie = 1'b0;
    expect_val("R3", S_IRQ, 16'd0);
    cmp_ie = 1'b1;

    // R5 low read without status read keeps flag
    bus_read(2'd1);
    expect_val("R5", S_FLAG, 16'd1);
    // R6 repeated match keeps flag
    strobe_value(16'h1234);
    expect_val("R6", S_FLAG, 16'd1);
    // R9 status image, then R5 armed clear by read
    bus_read(2'd2); expect_val("R9", S_RDATA, 16'h0040);
    bus_read(2'd1);
    expect_val("R5", S_FLAG, 16'd0);
    expect_val("R3", S_IRQ, 16'd0);

    // R5 status read while flag clear does not arm
    bus_read(2'd2); expect_val("R9", S_RDATA, 16'h0000);
    strobe_value(16'h1234);
    bus_read(2'd1);
    expect_val("R5", S_FLAG, 16'd1);
    // R5 armed clear by write
    bus_read(2'd2);
    bus_write(2'd1, 8'h34);
    expect_val("R5", S_FLAG, 16'd0);

    // R4 high write suspends compares
    bus_write(2'd0, 8'h12);
    strobe_value(16'h1234);
    expect_val("R4", S_FLAG, 16'd0);
    strobe_value(16'h1234);
    expect_val("R4", S_FLAG, 16'd0);
    bus_write(2'd1, 8'h34);
    strobe_value(16'h1234);
    expect_val("R4", S_FLAG, 16'd1);

    // R2 new value: old value no longer matches
    clear_flag();
    bus_write(2'd0, 8'hAB);
    bus_write(2'd1, 8'hCD);
    strobe_value(16'h1234);
    expect_val("R2", S_FLAG, 16'd0);
    strobe_value(16'hABCD);
    expect_val("R2", S_FLAG, 16'd1);

    // R7 pin mux
    pin_sel = 1'b0; port_dout0 = 1'b1; port_dir0 = 1'b0;
    expect_val("R7", S_PIN, 16'd1);
    expect_val("R7", S_OE, 16'd0);
    pin_sel = 1'b1;
    expect_val("R7", S_PIN, 16'd1);
    expect_val("R7", S_OE, 16'd1);
    clear_flag();
    expect_val("R7", S_PIN, 16'd0);
    pin_sel = 1'b0; port_dout0 = 1'b0; port_dir0 = 1'b1;
    expect_val("R7", S_PIN, 16'd0);
    expect_val("R7", S_OE, 16'd1);

    step();
    wait (sb_q.size() == 0);
    #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule